// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block is a down-counting tick timer for an always-on clock domain. It is clocked by the system clock. A one-cycle enable pulse at 32.768 kHz advances it. Software sets a 16-bit period in ticks through two byte registers and arms the timer from a control byte. The control byte holds the run enable, the interrupt enable, the expiry flag and the mode bit. In periodic mode the timer raises its flag once per period and refills itself. In one-shot mode it raises the flag once and then disarms itself. A period of `32768 >> n` ticks gives 2^n expiries per second.

Register access goes through a small 8-bit interface. It has an address, write data and a write strobe, and read data is combinational. That is the same interface used by the calendar registers next to it. A write of any value to a separate address restarts the period in progress. The upper nibble of the control byte is reserved for a watchdog that this block does not implement. Its busy bit always reads as idle.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the control byte (0x10), both period bytes (0x12, 0x13) and `irq` read as zero.
- R2: A write to 0x10 that sets bit 3 (run) while run is clear loads the counter from the period. The flag (bit 1) is set at the clock edge of the N-th following tick pulse, where N is the period value and a period of 0 means 65536.
- R3: With bit 0 = 1 (periodic), every expiry refills the counter, so each later period is again N ticks. A period of `0x8000 >> n` therefore gives 2^n expiries per 32768 ticks.
- R4: With bit 0 = 0 (one-shot), an expiry clears bit 3, and later tick pulses raise no further expiry.
- R5: Writing 0x10 with bit 1 = 1 clears the flag, and bit 1 = 0 leaves it unchanged. When an expiry and a clearing write fall in the same cycle, the flag ends set.
- R6: `irq` is high exactly when the flag and bit 2 (interrupt enable) are both set.
- R7: The period is written as a low byte at 0x12 and a high byte at 0x13, and both read back. A new period does not disturb the count in progress. It is used from the next load onward.
- R8: A write of any data to 0x20 reloads the counter from the period, so the next expiry is N ticks later. This write does not set the flag.
- R9: Bits 7..4 of 0x10 always read zero, including the watchdog busy bit 7. Writing ones to them has no effect.
- R10: Tick pulses while bit 3 is clear change neither the flag nor the count, and a later arm still counts a full N ticks.
- R11: Reads of addresses other than 0x10, 0x12 and 0x13 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz count rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Timer interrupt request (flag AND interrupt enable) |

## Verification
The flag has a hardware setter and a software clearer, and the two can land on the same clock edge. The bench provokes this by holding a tick pulse on the exact cycle the counter reaches its last count while it writes 1 to the flag bit. It then judges from the read port that the flag remained set. It also places a restart write and a period change in the middle of a running period. The expiry timing is checked against the arithmetic (remaining count, or the full new period) rather than the old period.

// File: rtl/tick_timer_pkg.sv
// Package: register addresses and control-bit positions shared by the
// tick timer modules. Assumes an 8-bit register address space.
package tick_timer_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CTRL    = 8'h10;
    localparam logic [REG_AW-1:0] ADDR_PERIOD0 = 8'h12;  // low byte first
    localparam logic [REG_AW-1:0] ADDR_RESTART = 8'h20;

    // Control byte layout (software decodes these positions).
    localparam int CB_MODE  = 0;  // 1 = periodic, 0 = one-shot
    localparam int CB_FLAG  = 1;  // expiry flag, write 1 to clear
    localparam int CB_IE    = 2;  // interrupt enable
    localparam int CB_RUN   = 3;  // run enable
    localparam int CB_WBUSY = 7;  // watchdog busy stub, reads 0

    typedef struct packed {
        logic run;
        logic ie;
        logic flag;
        logic periodic;
    } tick_ctrl_t;

endpackage

// File: rtl/tt_reg_block.sv
// Register block: holds the control fields and the byte-wide period
// register. Decodes the arm and restart strobes for the counter.
// Assumes a single-cycle write strobe and that CNT_W is a multiple of REG_DW.
module tt_reg_block
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              expire,
    output tick_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  period,
    output logic              start,
    output logic              restart
);
    localparam int NBYTES = CNT_W / REG_DW;

    logic ctrl_wr;
    logic flag_clr;

    // Write decode for the control byte, arm edge and restart address.
    always_comb begin
        ctrl_wr  = wr_en && (addr == ADDR_CTRL);
        flag_clr = ctrl_wr && wdata[CB_FLAG];
        start    = ctrl_wr && wdata[CB_RUN] && !ctrl.run;
        restart  = wr_en && (addr == ADDR_RESTART);
    end

    // Control fields: a software write wins for run/mode/ie; a one-shot expiry disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.run      <= 1'b0;
            ctrl.ie       <= 1'b0;
            ctrl.periodic <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl.run      <= wdata[CB_RUN];
            ctrl.ie       <= wdata[CB_IE];
            ctrl.periodic <= wdata[CB_MODE];
        end else if (expire && !ctrl.periodic) begin
            ctrl.run <= 1'b0;
        end
    end

    // Expiry flag: set by hardware, cleared by writing 1; set wins on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.flag <= 1'b0;
        end else begin
            ctrl.flag <= (ctrl.flag && !flag_clr) || expire;
        end
    end

    // One byte lane of the period register per generate step.
    for (genvar i = 0; i < NBYTES; i++) begin : g_period
        localparam logic [REG_AW-1:0] LANE_ADDR = ADDR_PERIOD0 + REG_AW'(i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                period[i*REG_DW +: REG_DW] <= '0;
            end else if (wr_en && (addr == LANE_ADDR)) begin
                period[i*REG_DW +: REG_DW] <= wdata;
            end
        end
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl.flag); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !expire) |=> !ctrl.flag); // R5
    AST_ONESHOT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl.periodic && !ctrl_wr) |=> !ctrl.run); // R4
    AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(period)); // R7

endmodule

// File: rtl/tt_down_counter.sv
// Down counter: loads the period on arm or restart, decrements on each
// tick pulse while running, and flags expiry on the tick that consumes
// the last count. A period of 0 wraps through all ones, giving 2^CNT_W ticks.
module tt_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             start,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] count;
    logic             load;

    // Expiry on the last count; a restart in the same cycle suppresses it.
    always_comb begin
        expire = run && tick_en && (count == LAST) && !restart;
        load   = start || restart || expire;
    end

    // Count register: load from the period, otherwise step down on a running tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= period;
        end else if (run && tick_en) begin
            count <= count - LAST;
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !start && !restart && (count != LAST))
        |=> (count == $past(count) - LAST)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick_en) && !start && !restart) |=> $stable(count)); // R10
    AST_EXPIRY_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(period))); // R3

endmodule

// File: rtl/tt_read_mux.sv
// Read mux: returns the register addressed by addr combinationally.
// Watchdog bits of the control byte, including its busy bit, read as zero.
module tt_read_mux
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [REG_AW-1:0] addr,
    input  tick_ctrl_t        ctrl,
    input  logic [CNT_W-1:0]  period,
    output logic [REG_DW-1:0] rdata
);
    localparam int NBYTES = CNT_W / REG_DW;

    // Address decode across the control byte and every period lane.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[CB_WBUSY] = 1'b0;
            rdata[CB_RUN]   = ctrl.run;
            rdata[CB_IE]    = ctrl.ie;
            rdata[CB_FLAG]  = ctrl.flag;
            rdata[CB_MODE]  = ctrl.periodic;
        end
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == ADDR_PERIOD0 + REG_AW'(i)) begin
                rdata = period[i*REG_DW +: REG_DW];
            end
        end
    end

endmodule

// File: rtl/periodic_tick_timer.sv
// Top: programmable periodic/one-shot tick timer behind an 8-bit register
// port. Assumes tick_en is a single-cycle pulse synchronous to clk.
module periodic_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    tick_ctrl_t       ctrl;
    logic [CNT_W-1:0] period;
    logic             start;
    logic             restart;
    logic             expire;

    tt_reg_block #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .expire  (expire),
        .ctrl    (ctrl),
        .period  (period),
        .start   (start),
        .restart (restart)
    );

    tt_down_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .tick_en (tick_en),
        .start   (start),
        .restart (restart),
        .period  (period),
        .expire  (expire)
    );

    tt_read_mux #(.CNT_W(CNT_W)) u_rd (
        .addr   (reg_addr),
        .ctrl   (ctrl),
        .period (period),
        .rdata  (reg_rdata)
    );

    // Interrupt request: flag gated by its enable.
    always_comb irq = ctrl.flag && ctrl.ie;

    AST_IRQ_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.ie && !(reg_wr && reg_addr == ADDR_CTRL)) |=> irq); // R6

endmodule

// File: tb/tb_periodic_tick_timer.sv
`timescale 1ns/1ps
module tb_periodic_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    periodic_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        reg_addr = 8'h10;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    // Pulse ticks until the flag reads set; returns the number of ticks.
    task automatic measure(input int max, output int n);
        n = 0;
        @(negedge clk);
        reg_addr = 8'h10;
        tick_en = 1'b1;
        while (n < max) begin
            @(negedge clk);
            n++;
            if (reg_rdata[1]) break;
        end
        tick_en = 1'b0;
    endtask

    task automatic arm(input int per, input logic [7:0] ctl);
        wr(8'h10, 8'h02);
        wr(8'h12, 8'(per));
        wr(8'h13, 8'(per >> 8));
        wr(8'h10, ctl);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h10, v); check("R1 ctrl", v, 0);
        rd(8'h12, v); check("R1 per lo", v, 0);
        rd(8'h13, v); check("R1 per hi", v, 0);
        check("R1 irq", irq, 0);
        // R11 unmapped reads
        rd(8'h11, v); check("R11 addr 0x11", v, 0);
        rd(8'h20, v); check("R11 addr 0x20", v, 0);
        // R10 ticks while disarmed
        wr(8'h12, 8'd5);
        ticks(20);
        rd(8'h10, v); check("R10 flag idle", v, 0);
        wr(8'h10, 8'h0D);
        measure(100, n); check("R10 full period after arm", n, 5);
        // R3 / R2 sweep over small periods
        for (int p = 1; p <= 16; p++) begin
            arm(p, 8'h0D);
            measure(100, n); check("R2 first period", n, p);
            check("R6 irq with ie", irq, 1);
            wr(8'h10, 8'h0F);
            rd(8'h10, v); check("R5 w1c", v[1], 0);
            measure(100, n); check("R3 second period", n, p);
        end
        // R3 power-of-two rates
        for (int s = 0; s < 16; s++) begin
            arm(32'h8000 >> s, 8'h0D);
            measure(40000, n);
            check("R3 rate", n * (1 << s), 32768);
        end
        // R2 zero period means 65536
        arm(0, 8'h0D);
        measure(70000, n); check("R2 zero period", n, 65536);
        // R7 readback
        arm(16'h1234, 8'h00);
        rd(8'h12, v); check("R7 lo", v, 8'h34);
        rd(8'h13, v); check("R7 hi", v, 8'h12);
        // R7 period change mid-count
        arm(10, 8'h0D);
        ticks(3);
        wr(8'h12, 8'd5);
        measure(100, n); check("R7 old count finishes", n, 7);
        wr(8'h10, 8'h0F);
        measure(100, n); check("R7 new period used", n, 5);
        // R8 restart
        arm(10, 8'h0D);
        ticks(4);
        wr(8'h20, 8'h55);
        rd(8'h10, v); check("R8 no flag", v[1], 0);
        measure(100, n); check("R8 restart period", n, 10);
        // R4 one-shot
        arm(3, 8'h0C);
        measure(100, n); check("R4 one-shot period", n, 3);
        rd(8'h10, v); check("R4 run cleared", v[3], 0);
        wr(8'h10, 8'h06);
        ticks(10);
        rd(8'h10, v); check("R4 no re-expiry", v[1], 0);
        // R5 set wins over same-cycle clear
        arm(2, 8'h0D);
        ticks(1);
        @(negedge clk);
        tick_en = 1'b1; reg_addr = 8'h10; reg_wdata = 8'h0F; reg_wr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        rd(8'h10, v); check("R5 set wins", v[1], 1);
        wr(8'h10, 8'h0D);
        rd(8'h10, v); check("R5 write 0 keeps", v[1], 1);
        wr(8'h10, 8'h0F);
        rd(8'h10, v); check("R5 clear", v[1], 0);
        // R6 irq gated by ie
        arm(2, 8'h09);
        measure(100, n);
        check("R6 irq masked", irq, 0);
        wr(8'h10, 8'h0D);
        check("R6 irq unmasked", irq, 1);
        // R9 watchdog bits
        wr(8'h10, 8'h02);
        wr(8'h10, 8'hF0);
        rd(8'h10, v); check("R9 upper zero", v, 0);
        wr(8'h10, 8'hF9);
        rd(8'h10, v); check("R9 only timer bits", v, 8'h09);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule